// File: doc/BRIEF.md
# Associative Road-Finding Pattern Bank

This block is a content-addressable bank of track patterns used to find candidate roads while detector hits are still streaming in. Each of the 128 patterns stores one 12-bit coarse-bin word for each of six detector layers. Every stored word has its own equality comparator. When a hit arrives with its layer code, all patterns compare it against their word for that layer at the same moment. A match sets a per-layer hit bit that stays set until the event is cleared. Pattern recognition is therefore complete as soon as the last hit of the event has been presented.

A pattern becomes a road when the number of its layers with a hit bit set reaches a programmable threshold. The threshold can be lowered so that a road is accepted with one or more layers missing. When the drain command is given, the block takes a snapshot of the matching patterns. It then emits their 7-bit addresses one per clock, lowest address first, and raises a done flag once none remain. Patterns are loaded and read back through a separate configuration path selected by a 4-bit opcode. The road outputs are intended for an external wired-OR merge of several banks.

The control is a three-state machine. In `S_COLLECT` the bank accepts hits, writes and threshold loads. `OP_DRAIN` moves it to `S_DRAIN`, where one road is emitted per cycle. When the snapshot is empty it moves to `S_DONE`. `OP_DRAIN` in `S_DONE` takes a fresh snapshot and re-enters `S_DRAIN`. `OP_CLEAR` returns the machine to `S_COLLECT` from any state.

Top module: `am_road_finder`

## Requirements
- R1: After reset, `road_valid_o`, `done_o` and `rdata_o` are 0 and the match threshold is 6, so a pattern needs all six layers hit.
- R2: Opcode 1 (write) in `S_COLLECT` stores `cfg_data_i` into word `cfg_layer_i` of pattern `cfg_addr_i`. Opcode 2 (read) shows that word on `rdata_o` after the next rising edge. A write to layer code 6 or 7 changes nothing, and a read of those codes returns 0.
- R3: A hit (`hit_valid_i` = 1 in `S_COLLECT`) sets the hit bit of layer `hit_layer_i` in every pattern whose word for that layer equals `hit_word_i`. The bit stays set until a clear, whatever the order of hits and however often they repeat.
- R4: Hits with layer code 6 or 7 set no hit bit in any pattern.
- R5: Opcode 3 in `S_COLLECT` loads `cfg_data_i[2:0]` as the threshold. A pattern is a road when the count of its set hit bits is at least the threshold.
- R6: Opcode 5 (drain), accepted in `S_COLLECT` or `S_DONE`, snapshots the roads. Starting on the cycle after the command, one road address per cycle appears on `road_addr_o` with `road_valid_o` = 1, in ascending address order.
- R7: On the cycle after the last road, or the cycle after the drain command when there is none, `road_valid_o` is 0 and `done_o` is 1. `done_o` then holds until opcode 4 or opcode 5.
- R8: Opcode 4 (clear), accepted in any state, empties all hit bits and the road snapshot and returns to `S_COLLECT`. A hit presented in the same cycle is ignored. On the next cycle `road_valid_o` and `done_o` are 0.
- R9: Hits presented in `S_DRAIN` or `S_DONE`, or in the cycle of a drain command, are ignored. Writes and threshold loads outside `S_COLLECT` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Opcode: 0 none, 1 write, 2 read, 3 load threshold, 4 clear event, 5 drain |
| cfg_addr_i | input | 7 | Pattern address for write and read |
| cfg_layer_i | input | 3 | Layer code for write and read |
| cfg_data_i | input | 12 | Write data; bits 2:0 are the threshold for opcode 3 |
| hit_valid_i | input | 1 | A hit is presented this cycle |
| hit_layer_i | input | 3 | Layer code of the hit, 0 to 5 valid |
| hit_word_i | input | 12 | Coarse-bin word of the hit |
| rdata_o | output | 12 | Read data, registered |
| road_valid_o | output | 1 | `road_addr_o` carries a road this cycle |
| road_addr_o | output | 7 | Address of the emitted road |
| done_o | output | 1 | All roads of the snapshot have been emitted |

## Verification
A hit, write or threshold load takes effect at the rising edge where it is presented. A read result is visible after that same edge. The first road appears one edge after the drain command, and each further road one edge later. The done flag follows one edge after the last road, and the effect of a clear shows one edge after it. The bench drives every input on the falling edge and returns them to idle just after the rising edge. It samples outputs 1 ns after the rising edge that is due to produce them, walking the drain one cycle per expected road computed from its own model of the bank and hit bits.

// File: rtl/am_pkg.sv
package am_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_WRITE   = 4'd1,
        OP_READ    = 4'd2,
        OP_SET_THR = 4'd3,
        OP_CLEAR   = 4'd4,
        OP_DRAIN   = 4'd5
    } am_op_e;

    typedef enum logic [1:0] {
        S_COLLECT = 2'd0,
        S_DRAIN   = 2'd1,
        S_DONE    = 2'd2
    } am_state_e;

endpackage

// File: rtl/am_pattern_row.sv
module am_pattern_row #(
    parameter int N_LAYER = 6,
    parameter int WORD_W  = 12,
    parameter int LSEL_W  = 3,
    parameter int THR_W   = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [LSEL_W-1:0]                 wr_layer,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic                              hit_en,
    input  logic [LSEL_W-1:0]                 hit_layer,
    input  logic [WORD_W-1:0]                 hit_word,
    input  logic                              clr_hits,
    input  logic [THR_W-1:0]                  thr,
    output logic [N_LAYER-1:0][WORD_W-1:0]    words_o,
    output logic                              match_o
);

    logic [N_LAYER-1:0] hit_bits_q;
    logic [THR_W-1:0]   layer_cnt;

    for (genvar l = 0; l < N_LAYER; l++) begin : g_layer
        logic word_eq;

        // private comparator for this stored word
        assign word_eq = (hit_word == words_o[l]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_o[l] <= '0;
            end else if (wr_en && (wr_layer == LSEL_W'(l))) begin
                words_o[l] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hit_bits_q[l] <= 1'b0;
            end else if (clr_hits) begin
                hit_bits_q[l] <= 1'b0;
            end else if (hit_en && (hit_layer == LSEL_W'(l)) && word_eq) begin
                hit_bits_q[l] <= 1'b1;
            end
        end
    end

    always_comb begin
        layer_cnt = '0;
        for (int l = 0; l < N_LAYER; l++) begin
            layer_cnt = layer_cnt + THR_W'(hit_bits_q[l]);
        end
    end

    assign match_o = (layer_cnt >= thr);

endmodule

// File: rtl/am_prio_enc.sv
module am_prio_enc #(
    parameter int N     = 128,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    // scan from the top down so the lowest set index wins
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/am_ctrl.sv
module am_ctrl
    import am_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  am_op_e op,
    input  logic   pending_any,
    output logic   hit_ok,
    output logic   wr_ok,
    output logic   thr_ld,
    output logic   clr,
    output logic   snap,
    output logic   pop,
    output logic   done_o
);

    am_state_e state_q;
    am_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_COLLECT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COLLECT: begin
                if (op == OP_DRAIN) state_d = S_DRAIN;
            end
            S_DRAIN: begin
                if (op == OP_CLEAR)     state_d = S_COLLECT;
                else if (!pending_any)  state_d = S_DONE;
            end
            S_DONE: begin
                if (op == OP_CLEAR)      state_d = S_COLLECT;
                else if (op == OP_DRAIN) state_d = S_DRAIN;
            end
            default: state_d = S_COLLECT;
        endcase
    end

    always_comb begin
        hit_ok = 1'b0;
        wr_ok  = 1'b0;
        thr_ld = 1'b0;
        snap   = 1'b0;
        pop    = 1'b0;
        done_o = 1'b0;
        clr    = (op == OP_CLEAR);
        unique case (state_q)
            S_COLLECT: begin
                hit_ok = (op != OP_CLEAR) && (op != OP_DRAIN);
                wr_ok  = (op == OP_WRITE);
                thr_ld = (op == OP_SET_THR);
                snap   = (op == OP_DRAIN);
            end
            S_DRAIN: begin
                pop = pending_any && (op != OP_CLEAR);
            end
            S_DONE: begin
                done_o = 1'b1;
                snap   = (op == OP_DRAIN);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/am_drain.sv
module am_drain #(
    parameter int N     = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap,
    input  logic [N-1:0]     snap_vec,
    input  logic             pop,
    input  logic             clr,
    output logic             pending_any,
    output logic             road_valid_o,
    output logic [IDX_W-1:0] road_addr_o
);

    logic [N-1:0]     pending_q;
    logic [IDX_W-1:0] low_idx;

    am_prio_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
        .req   (pending_q),
        .idx   (low_idx),
        .found (pending_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else if (clr) begin
            pending_q <= '0;
        end else if (snap) begin
            pending_q <= snap_vec;
        end else if (pop) begin
            pending_q[low_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            road_valid_o <= 1'b0;
            road_addr_o  <= '0;
        end else begin
            road_valid_o <= pop;
            if (pop) road_addr_o <= low_idx;
        end
    end

endmodule

// File: rtl/am_road_finder.sv
module am_road_finder
    import am_pkg::*;
#(
    parameter int N_PAT   = 128,
    parameter int N_LAYER = 6,
    parameter int WORD_W  = 12,
    parameter int LSEL_W  = 3,
    parameter int ADDR_W  = $clog2(N_PAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [LSEL_W-1:0] cfg_layer_i,
    input  logic [WORD_W-1:0] cfg_data_i,
    input  logic              hit_valid_i,
    input  logic [LSEL_W-1:0] hit_layer_i,
    input  logic [WORD_W-1:0] hit_word_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              road_valid_o,
    output logic [ADDR_W-1:0] road_addr_o,
    output logic              done_o
);

    localparam int THR_W = $clog2(N_LAYER + 1);

    am_op_e     op;
    logic       hit_ok, wr_ok, thr_ld, clr, snap, pop, pending_any;
    logic       hit_go, layer_ok;
    logic [THR_W-1:0] thr_q;
    logic [N_PAT-1:0] match_vec;
    logic [N_PAT-1:0][N_LAYER-1:0][WORD_W-1:0] all_words;

    assign op       = am_op_e'(op_i);
    assign hit_go   = hit_valid_i && hit_ok;
    assign layer_ok = (cfg_layer_i < LSEL_W'(N_LAYER));

    am_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .pending_any (pending_any),
        .hit_ok      (hit_ok),
        .wr_ok       (wr_ok),
        .thr_ld      (thr_ld),
        .clr         (clr),
        .snap        (snap),
        .pop         (pop),
        .done_o      (done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= THR_W'(N_LAYER);
        end else if (thr_ld) begin
            thr_q <= cfg_data_i[THR_W-1:0];
        end
    end

    for (genvar p = 0; p < N_PAT; p++) begin : g_row
        am_pattern_row #(
            .N_LAYER (N_LAYER),
            .WORD_W  (WORD_W),
            .LSEL_W  (LSEL_W),
            .THR_W   (THR_W)
        ) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_ok && (cfg_addr_i == ADDR_W'(p))),
            .wr_layer  (cfg_layer_i),
            .wr_data   (cfg_data_i),
            .hit_en    (hit_go),
            .hit_layer (hit_layer_i),
            .hit_word  (hit_word_i),
            .clr_hits  (clr),
            .thr       (thr_q),
            .words_o   (all_words[p]),
            .match_o   (match_vec[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (op == OP_READ) begin
            rdata_o <= layer_ok ? all_words[cfg_addr_i][cfg_layer_i] : '0;
        end
    end

    am_drain #(.N(N_PAT), .IDX_W(ADDR_W)) u_drain (
        .clk          (clk),
        .rst_n        (rst_n),
        .snap         (snap),
        .snap_vec     (match_vec),
        .pop          (pop),
        .clr          (clr),
        .pending_any  (pending_any),
        .road_valid_o (road_valid_o),
        .road_addr_o  (road_addr_o)
    );

endmodule

// File: rtl/am_road_finder_chk.sv
module am_road_finder_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic              road_valid_o,
    input logic [ADDR_W-1:0] road_addr_o,
    input logic              done_o
);

    // R6: consecutive roads come out in strictly rising address order
    p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (road_valid_o && $past(road_valid_o)) |-> (road_addr_o > $past(road_addr_o)));

    // R7: a road and the done flag never coincide
    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(road_valid_o && done_o));

    // R7: done holds while neither clear nor drain is issued
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (op_i != 4'd4) && (op_i != 4'd5)) |=> done_o);

    // R8: after a clear both road and done outputs are low
    p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4) |=> (!road_valid_o && !done_o));

    // R6: a drain command never yields done on the very next cycle while a road is shown
    p_drain_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 4'd5) && done_o) |=> !done_o || !road_valid_o);

endmodule

bind am_road_finder am_road_finder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .road_valid_o (road_valid_o),
    .road_addr_o  (road_addr_o),
    .done_o       (done_o)
);

// File: tb/tb_am_road_finder.sv
module tb_am_road_finder;

    localparam int N_PAT   = 128;
    localparam int N_LAYER = 6;
    localparam int WORD_W  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [6:0]  cfg_addr_i = '0;
    logic [2:0]  cfg_layer_i = '0;
    logic [11:0] cfg_data_i = '0;
    logic        hit_valid_i = 1'b0;
    logic [2:0]  hit_layer_i = '0;
    logic [11:0] hit_word_i = '0;
    logic [11:0] rdata_o;
    logic        road_valid_o;
    logic [6:0]  road_addr_o;
    logic        done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [11:0] bank [N_PAT][N_LAYER];
    logic [5:0]  hb   [N_PAT];
    int          thr_m = 6;

    always #4 clk = ~clk;

    am_road_finder dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i),
        .cfg_addr_i(cfg_addr_i), .cfg_layer_i(cfg_layer_i), .cfg_data_i(cfg_data_i),
        .hit_valid_i(hit_valid_i), .hit_layer_i(hit_layer_i), .hit_word_i(hit_word_i),
        .rdata_o(rdata_o), .road_valid_o(road_valid_o), .road_addr_o(road_addr_o),
        .done_o(done_o)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] op, input int addr, input int layer,
                       input int data, input logic hv, input int hl, input int hw);
        @(negedge clk);
        op_i        = op;
        cfg_addr_i  = 7'(addr);
        cfg_layer_i = 3'(layer);
        cfg_data_i  = 12'(data);
        hit_valid_i = hv;
        hit_layer_i = 3'(hl);
        hit_word_i  = 12'(hw);
        @(posedge clk);
        #1;
        op_i        = 4'd0;
        hit_valid_i = 1'b0;
    endtask

    task automatic wr(int p, int l, int d, bit accepted);
        cyc(4'd1, p, l, d, 1'b0, 0, 0);
        if (accepted && l < N_LAYER) bank[p][l] = 12'(d);
    endtask

    task automatic rd(string req, int p, int l);
        int exp;
        exp = (l < N_LAYER) ? int'(bank[p][l]) : 0;
        cyc(4'd2, p, l, 0, 1'b0, 0, 0);
        check(req, "read data", int'(rdata_o), exp);
    endtask

    task automatic hit(int l, int w, bit accepted);
        cyc(4'd0, 0, 0, 0, 1'b1, l, w);
        if (accepted && l < N_LAYER)
            for (int p = 0; p < N_PAT; p++)
                if (bank[p][l] == 12'(w)) hb[p][l] = 1'b1;
    endtask

    task automatic clear_ev();
        cyc(4'd4, 0, 0, 0, 1'b0, 0, 0);
        for (int p = 0; p < N_PAT; p++) hb[p] = '0;
    endtask

    task automatic set_thr(int t);
        cyc(4'd3, 0, 0, t, 1'b0, 0, 0);
        thr_m = t;
    endtask

    task automatic drain_check(string req);
        cyc(4'd5, 0, 0, 0, 1'b0, 0, 0);
        for (int p = 0; p < N_PAT; p++) begin
            if ($countones(hb[p]) >= thr_m) begin
                cyc(4'd0, 0, 0, 0, 1'b0, 0, 0);
                check(req, "road valid", int'(road_valid_o), 1);
                check(req, "road address", int'(road_addr_o), p);
            end
        end
        cyc(4'd0, 0, 0, 0, 1'b0, 0, 0);
        check("R7", "valid after last road", int'(road_valid_o), 0);
        check("R7", "done after last road", int'(done_o), 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int p = 0; p < N_PAT; p++) begin
            hb[p] = '0;
            for (int l = 0; l < N_LAYER; l++) bank[p][l] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "road valid at reset", int'(road_valid_o), 0);
        check("R1", "done at reset", int'(done_o), 0);
        check("R1", "read data at reset", int'(rdata_o), 0);

        // load the bank with small random bins, plus directed patterns
        for (int p = 0; p < N_PAT; p++)
            for (int l = 0; l < N_LAYER; l++)
                wr(p, l, int'($urandom % 8), 1'b1);
        for (int l = 0; l < N_LAYER; l++) begin
            wr(5, l, 12'hABC, 1'b1);
            wr(90, l, (l == 5) ? 12'h123 : 12'hABC, 1'b1);
            wr(127, l, 12'hFFF, 1'b1);
        end

        // R2: read back and invalid layer write
        for (int k = 0; k < 8; k++) rd("R2", int'($urandom % N_PAT), int'($urandom % N_LAYER));
        wr(5, 6, 12'h777, 1'b0);
        rd("R2", 5, 6);
        for (int l = 0; l < N_LAYER; l++) rd("R2", 5, l);

        // R1/R3/R4: default threshold, reversed and repeated hits, invalid layers
        for (int l = N_LAYER - 1; l >= 0; l--) hit(l, 12'hABC, 1'b1);
        hit(2, 12'hABC, 1'b1);
        for (int l = 0; l < 5; l++) hit(l, 12'hFFF, 1'b1);
        hit(6, 12'hFFF, 1'b0);
        hit(7, 12'hFFF, 1'b0);
        drain_check("R3 R4 R1");

        // R9: hit and write in the done state are ignored; re-drain from done
        hit(5, 12'h123, 1'b0);
        wr(127, 5, 12'h000, 1'b0);
        rd("R9", 127, 5);
        drain_check("R9");

        // R5: lower threshold accepts a road with one layer missing
        clear_ev();
        set_thr(5);
        for (int l = 0; l < N_LAYER; l++) hit(l, 12'hABC, 1'b1);
        for (int l = 0; l < 5; l++) hit(l, 12'hFFF, 1'b1);
        drain_check("R5");

        // R6: random events against the model
        clear_ev();
        set_thr(4);
        for (int k = 0; k < 40; k++) hit(int'($urandom % 8), int'($urandom % 8), 1'b1);
        drain_check("R6");
        clear_ev();
        set_thr(3);
        for (int k = 0; k < 25; k++) hit(int'($urandom % 8), int'($urandom % 8), 1'b1);
        drain_check("R6");

        // R8: clear in the middle of a drain, with a concurrent hit
        clear_ev();
        for (int l = 0; l < N_LAYER; l++) hit(l, 12'hABC, 1'b1);
        cyc(4'd5, 0, 0, 0, 1'b0, 0, 0);
        cyc(4'd0, 0, 0, 0, 1'b0, 0, 0);
        check("R8", "first road before clear", int'(road_addr_o), 5);
        cyc(4'd4, 0, 0, 0, 1'b1, 0, 12'hABC);
        for (int p = 0; p < N_PAT; p++) hb[p] = '0;
        check("R8", "valid after clear", int'(road_valid_o), 0);
        check("R8", "done after clear", int'(done_o), 0);
        set_thr(1);
        drain_check("R8 R7");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule